// File: doc/BRIEF.md
# Shared-memory doorbell register block

This block is the register front end of a device through which several domains share a memory region and ring each other's doorbells. Software reaches it with 32-bit accesses over a simple valid/ready bus. The register window is 256 bytes. It holds an interrupt enable mask, an interrupt status word that clears when it is read, and a read-only word that reports this domain's own position among the peers. A local event input sets bit 0 of the status word. The level interrupt output is high whenever a status bit and its mask bit are both set.

A write to the doorbell word names a destination peer in its upper half and a vector in its low byte. The block checks that the destination is below the live peer count. It then checks that the vector is below the count of vectors that peer has registered, taken from a per-peer lookup input. Only a doorbell that passes both checks produces a notify strobe. The strobe lasts one cycle and carries the destination and the vector to the transport logic outside the block.

Top module: `shm_doorbell_regs`

## Requirements
- R1: A synchronous active-high reset clears the mask and the status to zero. While reset is high, req_ready, irq, rsp_valid and notify_valid are low. req_ready is high from the first cycle after reset.
- R2: The word offsets are 0x0 for the mask (read/write, all 32 bits) and 0x8 for the own-position word. A read of 0x8 returns own_id zero-extended to 32 bits.
- R3: Only req_addr[7:2] selects the register. Address bits 1:0 and all bits above bit 7 have no effect on reads or writes.
- R4: A read of the status word at offset 0x4 returns its value and clears it to zero in the same access. A write to 0x4 loads the written value.
- R5: A cycle with status_set high leaves status bit 0 at one. This holds even when a status read clears the word in that cycle, and also when a status write lands in that cycle.
- R6: A write to offset 0xC is a doorbell. Bits 31:16 are the destination and bits 7:0 are the vector. A valid doorbell raises notify_valid for exactly one cycle, the cycle after the write is accepted, with notify_peer and notify_vector equal to those fields.
- R7: A doorbell is dropped with no notify if its destination is greater than or equal to peer_count or greater than or equal to MAX_PEERS.
- R8: A doorbell is dropped with no notify if its vector is greater than or equal to the destination's entry in peer_vcnt. Entry i sits at bits [i*VCNT_W +: VCNT_W].
- R9: Reads of any offset other than 0x0, 0x4 and 0x8 return zero. This includes the doorbell at 0xC. Writes to 0x8 and to undefined offsets change neither the mask nor the status.
- R10: irq equals the OR of (status AND mask), as seen in the same cycle as the updated registers.
- R11: An accepted read gives rsp_valid high for one cycle in the next cycle, with rsp_rdata holding the read value. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address. Only bits 7:2 are decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| own_id | input | 16 | This domain's position, returned at offset 0x8 |
| peer_count | input | PCNT_W | Number of peers currently present |
| peer_vcnt | input | MAX_PEERS*VCNT_W | Registered vector count of each peer |
| status_set | input | 1 | Local event, sets status bit 0 |
| irq | output | 1 | Masked interrupt level |
| notify_valid | output | 1 | One-cycle doorbell strobe |
| notify_peer | output | 16 | Destination of the strobe |
| notify_vector | output | 8 | Vector of the strobe |

## Verification
The bench builds the block with MAX_PEERS=4, VCNT_W=9 and ADDR_W=12. With those values peer_count can reach 7, which is above the size of the lookup table, so the table bound of R7 is tested apart from the live count. A vector count of 256 lets vector 255 pass, and a count of 0 rejects every vector, so both ends of R8 are covered. The four spare address bits above bit 7 are driven with random values to test R3.

// File: rtl/shm_doorbell_pkg.sv
package shm_doorbell_pkg;

  localparam int DATA_W     = 32;
  localparam int DST_LSB    = 16;
  localparam int DST_W      = 16;
  localparam int VEC_W      = 8;

  typedef enum logic [2:0] {
    RS_MASK,
    RS_STAT,
    RS_ID,
    RS_BELL,
    RS_NONE
  } reg_sel_e;

  // word index = byte offset >> 2
  function automatic reg_sel_e decode_word(input logic [5:0] word);
    case (word)
      6'd0:    return RS_MASK;
      6'd1:    return RS_STAT;
      6'd2:    return RS_ID;
      6'd3:    return RS_BELL;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/shm_reg_core.sv
module shm_reg_core
  import shm_doorbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic              rd_any,
  input  reg_sel_e          rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DST_W-1:0]  own_id,
  input  logic              status_set,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] mask_nx, stat_nx, stat_base, rd_mux;
  logic              rd_stat;
  logic              irq_q, rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  always_comb begin
    rd_stat = rd_any && (rd_sel == RS_STAT);
    mask_nx = wr_mask ? wdata : mask_q;
    if (rd_stat)      stat_base = '0;
    else if (wr_stat) stat_base = wdata;
    else              stat_base = stat_q;
    // local event is merged last so it is never lost
    stat_nx = stat_base | {{(DATA_W-1){1'b0}}, status_set};
    case (rd_sel)
      RS_MASK: rd_mux = mask_q;
      RS_STAT: rd_mux = stat_q;
      RS_ID:   rd_mux = {{(DATA_W-DST_W){1'b0}}, own_id};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '0;
      stat_q      <= '0;
      irq_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      mask_q      <= mask_nx;
      stat_q      <= stat_nx;
      irq_q       <= |(stat_nx & mask_nx);
      rsp_valid_q <= rd_any;
      if (rd_any) rsp_rdata_q <= rd_mux;
    end
  end

  assign irq       = irq_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/shm_bell_gate.sv
module shm_bell_gate
  import shm_doorbell_pkg::*;
#(
  parameter int MAX_PEERS = 16,
  parameter int VCNT_W    = 9,
  parameter int PCNT_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bell_wr,
  input  logic [DST_W-1:0]            dst,
  input  logic [VEC_W-1:0]            vec,
  input  logic [PCNT_W-1:0]           peer_count,
  input  logic [MAX_PEERS*VCNT_W-1:0] peer_vcnt,
  output logic                        notify_valid,
  output logic [DST_W-1:0]            notify_peer,
  output logic [VEC_W-1:0]            notify_vector
);

  localparam int IDX_W = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1;

  logic [VCNT_W-1:0] cnt_tab [MAX_PEERS];
  logic [VCNT_W-1:0] cnt_sel;
  logic              dst_ok, vec_ok, fire;

  for (genvar i = 0; i < MAX_PEERS; i++) begin : g_tab
    assign cnt_tab[i] = peer_vcnt[i*VCNT_W +: VCNT_W];
  end

  always_comb begin
    dst_ok  = (32'(dst) < 32'(peer_count)) && (32'(dst) < MAX_PEERS);
    cnt_sel = dst_ok ? cnt_tab[dst[IDX_W-1:0]] : '0;
    vec_ok  = 32'(vec) < 32'(cnt_sel);
    fire    = bell_wr && dst_ok && vec_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      notify_valid  <= 1'b0;
      notify_peer   <= '0;
      notify_vector <= '0;
    end else begin
      notify_valid <= fire;
      if (fire) begin
        notify_peer   <= dst;
        notify_vector <= vec;
      end
    end
  end

endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import shm_doorbell_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MAX_PEERS = 16,
  parameter int VCNT_W    = 9,
  localparam int PCNT_W   = $clog2(MAX_PEERS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [31:0]                 req_wdata,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_rdata,
  input  logic [15:0]                 own_id,
  input  logic [PCNT_W-1:0]           peer_count,
  input  logic [MAX_PEERS*VCNT_W-1:0] peer_vcnt,
  input  logic                        status_set,
  output logic                        irq,
  output logic                        notify_valid,
  output logic [15:0]                 notify_peer,
  output logic [7:0]                  notify_vector
);

  logic        ready_q, acc;
  reg_sel_e    sel;
  logic        wr_mask, wr_stat, rd_any, bell_wr;
  logic [31:0] mask_q, stat_q;
  logic        addr_unused;

  // only word bits 7:2 decode; the rest of the address is dropped
  assign addr_unused = ^{req_addr[ADDR_W-1:8], req_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  always_comb begin
    acc     = req_valid && ready_q;
    sel     = decode_word(req_addr[7:2]);
    wr_mask = acc && req_write && (sel == RS_MASK);
    wr_stat = acc && req_write && (sel == RS_STAT);
    bell_wr = acc && req_write && (sel == RS_BELL);
    rd_any  = acc && !req_write;
  end

  shm_reg_core u_core (
    .clk        (clk),
    .rst        (rst),
    .wr_mask    (wr_mask),
    .wr_stat    (wr_stat),
    .rd_any     (rd_any),
    .rd_sel     (sel),
    .wdata      (req_wdata),
    .own_id     (own_id),
    .status_set (status_set),
    .mask_q     (mask_q),
    .stat_q     (stat_q),
    .irq        (irq),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  shm_bell_gate #(
    .MAX_PEERS (MAX_PEERS),
    .VCNT_W    (VCNT_W),
    .PCNT_W    (PCNT_W)
  ) u_gate (
    .clk           (clk),
    .rst           (rst),
    .bell_wr       (bell_wr),
    .dst           (req_wdata[DST_LSB +: DST_W]),
    .vec           (req_wdata[VEC_W-1:0]),
    .peer_count    (peer_count),
    .peer_vcnt     (peer_vcnt),
    .notify_valid  (notify_valid),
    .notify_peer   (notify_peer),
    .notify_vector (notify_vector)
  );

endmodule

// File: rtl/shm_doorbell_checker.sv
module shm_doorbell_checker #(
  parameter int ADDR_W = 12,
  parameter int PCNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [PCNT_W-1:0] peer_count,
  input logic              status_set,
  input logic              irq,
  input logic              notify_valid,
  input logic [15:0]       notify_peer,
  input logic [7:0]        notify_vector,
  input logic [31:0]       mask_q,
  input logic [31:0]       stat_q
);

  logic acc;
  assign acc = req_valid && req_ready;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!notify_valid && !rsp_valid && !irq && mask_q == 32'd0 && stat_q == 32'd0));

  p_notify_src_r6: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> $past(acc && req_write && req_addr[7:2] == 6'd3));

  p_notify_fields_r6: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> (notify_peer == $past(req_wdata[31:16]) &&
                      notify_vector == $past(req_wdata[7:0])));

  p_dest_range_r7: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> (32'(notify_peer) < 32'($past(peer_count))));

  p_rsp_src_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(acc && !req_write));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    $past(acc && !req_write && req_addr[7:2] == 6'd1 && !status_set) |-> stat_q == 32'd0);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    $past(status_set && !rst) |-> stat_q[0]);

  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & mask_q));

  p_id_readonly_r9: assert property (@(posedge clk) disable iff (rst)
    $past(acc && req_write && req_addr[7:2] == 6'd2 && !status_set && !rst)
      |-> (mask_q == $past(mask_q) && stat_q == $past(stat_q)));

endmodule

bind shm_doorbell_regs shm_doorbell_checker #(
  .ADDR_W (ADDR_W),
  .PCNT_W (PCNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .rsp_valid     (rsp_valid),
  .peer_count    (peer_count),
  .status_set    (status_set),
  .irq           (irq),
  .notify_valid  (notify_valid),
  .notify_peer   (notify_peer),
  .notify_vector (notify_vector),
  .mask_q        (mask_q),
  .stat_q        (stat_q)
);

// File: tb/shm_doorbell_regs_bench.sv
`timescale 1ns/1ps
module shm_doorbell_regs_bench;

  localparam int AW  = 12;
  localparam int MP  = 4;
  localparam int VW  = 9;
  localparam int PCW = $clog2(MP + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           req_ready, rsp_valid, irq, notify_valid;
  logic [31:0]    rsp_rdata;
  logic [15:0]    own_id = 16'hA5C3;
  logic [PCW-1:0] peer_count = '0;
  logic [MP*VW-1:0] peer_vcnt = '0;
  logic           status_set = 1'b0;
  logic [15:0]    notify_peer;
  logic [7:0]     notify_vector;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mask_m = '0, stat_m = '0;
  int vc [MP];

  always #10 clk = ~clk;

  shm_doorbell_regs #(.ADDR_W(AW), .MAX_PEERS(MP), .VCNT_W(VW)) u_shm_doorbell_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .own_id(own_id),
    .peer_count(peer_count), .peer_vcnt(peer_vcnt), .status_set(status_set),
    .irq(irq), .notify_valid(notify_valid), .notify_peer(notify_peer),
    .notify_vector(notify_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_table(input int a0, input int a1, input int a2, input int a3);
    vc[0] = a0; vc[1] = a1; vc[2] = a2; vc[3] = a3;
    for (int i = 0; i < MP; i++) peer_vcnt[i*VW +: VW] = VW'(vc[i]);
  endtask

  function automatic logic [31:0] exp_read(input logic [5:0] word);
    case (word)
      6'd0:    return mask_m;
      6'd1:    return stat_m;
      6'd2:    return {16'd0, own_id};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [5:0] word);
    case (word)
      6'd0, 6'd2: return "R2 read";
      6'd1:       return "R4 status read";
      default:    return "R9 undefined read";
    endcase
  endfunction

  // one bus access, then compare everything against the model
  task automatic op(input bit wr, input logic [3:0] hi, input logic [5:0] word,
                    input logic [1:0] lo, input logic [31:0] d, input bit setev,
                    input string tag);
    logic [31:0] rexp;
    bit dst_ok, vec_ok;
    int dst, vec;
    rexp = exp_read(word);
    dst = int'(d[31:16]);
    vec = int'(d[7:0]);
    dst_ok = (dst < int'(peer_count)) && (dst < MP);
    vec_ok = dst_ok && (vec < vc[dst]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {hi, word, lo};
    req_wdata = d; status_set = setev;
    @(negedge clk);
    req_valid = 1'b0; status_set = 1'b0;
    // model update
    if (!wr && word == 6'd1) stat_m = 32'd0;
    if (wr && word == 6'd0) mask_m = d;
    if (wr && word == 6'd1) stat_m = d;
    if (setev) stat_m[0] = 1'b1;
    if (!wr) begin
      chk(rsp_valid == 1'b1, "R11 rsp_valid", 32'(rsp_valid), 32'd1);
      chk(rsp_rdata == rexp, (tag != "") ? tag : read_tag(word), rsp_rdata, rexp);
    end else begin
      chk(rsp_valid == 1'b0, "R11 no write rsp", 32'(rsp_valid), 32'd0);
    end
    chk(irq == |(stat_m & mask_m), "R10 irq", 32'(irq), 32'(|(stat_m & mask_m)));
    if (wr && word == 6'd3) begin
      chk(notify_valid == vec_ok, !dst_ok ? "R7 dest range" : (!vec_ok ? "R8 vector range" : "R6 notify"),
          32'(notify_valid), 32'(vec_ok));
      if (vec_ok) begin
        chk(notify_peer == d[31:16] && notify_vector == d[7:0], "R6 notify fields",
            {notify_peer, 8'd0, notify_vector}, {d[31:16], 8'd0, d[7:0]});
      end
      @(negedge clk);
      chk(notify_valid == 1'b0, "R6 single pulse", 32'(notify_valid), 32'd0);
    end else begin
      chk(notify_valid == 1'b0, "R6 no stray notify", 32'(notify_valid), 32'd0);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 && irq == 1'b0 && notify_valid == 1'b0 && rsp_valid == 1'b0,
        "R1 outputs in reset", {req_ready, irq, notify_valid, rsp_valid}, 32'd0);
    rst = 1'b0;
    mask_m = '0; stat_m = '0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    load_table(3, 0, 256, 1);
    peer_count = PCW'(3);
    do_reset();
    // R1: registers read back zero
    op(0, 4'h0, 6'd0, 2'd0, 32'd0, 0, "R1 mask after reset");
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 0, "R1 status after reset");
    // R2 / R3: mask through aliased address
    op(1, 4'hF, 6'd0, 2'd3, 32'hDEAD_BEEF, 0, "");
    op(0, 4'h0, 6'd0, 2'd0, 32'd0, 0, "R3 alias write");
    op(0, 4'h9, 6'd2, 2'd1, 32'd0, 0, "R3 alias id read");
    // R4 write then read-to-clear
    op(1, 4'h0, 6'd1, 2'd0, 32'h0000_0F00, 0, "");
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 0, "R4 first read");
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 0, "R4 cleared");
    // R5 set wins over clearing read, and over write
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 1, "R5 read during set");
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 0, "R5 set kept");
    op(1, 4'h0, 6'd1, 2'd0, 32'h0000_0010, 1, "");
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 0, "R5 set over write");
    // R9 writes to id and undefined offsets ignored
    op(1, 4'h0, 6'd2, 2'd0, 32'hFFFF_FFFF, 0, "");
    op(1, 4'h0, 6'd7, 2'd0, 32'hFFFF_FFFF, 0, "");
    op(0, 4'h0, 6'd0, 2'd0, 32'd0, 0, "R9 mask untouched");
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 0, "R9 status untouched");
    op(0, 4'h0, 6'd3, 2'd0, 32'd0, 0, "R9 doorbell reads zero");
    op(0, 4'h0, 6'd63, 2'd0, 32'd0, 0, "R9 top offset");
    // doorbell corners: R6 valid, R7 dest, R8 vector
    op(1, 4'h0, 6'd3, 2'd0, {16'd0, 8'h55, 8'd2}, 0, "");
    op(1, 4'h0, 6'd3, 2'd0, {16'd0, 8'h00, 8'd3}, 0, "");
    op(1, 4'h0, 6'd3, 2'd0, {16'd1, 8'h00, 8'd0}, 0, "");
    op(1, 4'h0, 6'd3, 2'd0, {16'd2, 8'h00, 8'd255}, 0, "");
    op(1, 4'h0, 6'd3, 2'd0, {16'd3, 8'h00, 8'd0}, 0, "");
    peer_count = PCW'(7);
    op(1, 4'h0, 6'd3, 2'd0, {16'd3, 8'h00, 8'd0}, 0, "");
    op(1, 4'h0, 6'd3, 2'd0, {16'd5, 8'h00, 8'd0}, 0, "");
    op(1, 4'h0, 6'd3, 2'd0, {16'hFFFF, 8'h00, 8'd0}, 0, "");
    // random mix
    for (int k = 0; k < 600; k++) begin
      int kind;
      logic [5:0] w;
      logic [31:0] d;
      if (k % 100 == 0) begin
        load_table($urandom_range(0, 4), $urandom_range(0, 256),
                   $urandom_range(0, 20), $urandom_range(250, 256));
        peer_count = PCW'($urandom_range(0, 7));
        own_id = 16'($urandom);
      end
      kind = $urandom_range(0, 9);
      w = (kind < 8) ? 6'($urandom_range(0, 3)) : 6'($urandom_range(4, 63));
      d = $urandom;
      if (w == 6'd3) d[31:16] = 16'($urandom_range(0, 6));
      op(kind[0], 4'($urandom), w, 2'($urandom), d, ($urandom_range(0, 5) == 0), "");
    end
    // R1 reset mid-run
    op(1, 4'h0, 6'd0, 2'd0, 32'h0000_0001, 1, "");
    do_reset();
    op(0, 4'h0, 6'd0, 2'd0, 32'd0, 0, "R1 mask cleared by reset");
    op(0, 4'h0, 6'd1, 2'd0, 32'd0, 0, "R1 status cleared by reset");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule